// File: doc/BRIEF.md
# Parallel camera capture with chained buffers

This block takes bytes from a parallel camera port (8-bit data, pixel clock, line-valid strobe and frame sync) and packs them into a chain of 32-bit words. The chain holds 1, 4 or 8 words (32, 128 or 256 bits). One transfer request is raised only when every word in the chain is full. A reader then drains the chain as a stream of 32-bit words.

The camera inputs are treated as signals already synchronous to the system clock. A byte is taken only when the pixel clock is seen going from low to high while the line is valid. A pixel clock that sits high through blanking therefore adds nothing, even when line-valid rises under it.

An optional swap exchanges the two bytes of each 16-bit pixel, for sensors that send the colour bytes in reversed order. A side port lets any word be peeked at without disturbing the stream. A per-word full mask and a sticky overflow flag report the state of the chain.

Top module: `cam_chain_capture`

## Requirements
- R1: After reset, out_valid, overflow and every bit of full_mask are 0.
- R2: A byte is taken only in a clock cycle where cam_pclk is 1, cam_pclk was 0 in the previous cycle, and cam_lval is 1. A rise of cam_lval while cam_pclk is already high takes no byte, and pixel clock edges while cam_lval is 0 take no byte.
- R3: No byte is taken until cam_fsync has been seen rising after reset. A level that is already high at reset does not count as a rise.
- R4: Bytes are numbered k = 0, 1, 2 ... within a chain. With swap_en=0, byte k lands in word k/4 at bits [8*(k%4)+7 : 8*(k%4)]. With swap_en=1, byte k lands at the place of byte k^1, so the two bytes of each 16-bit pixel trade places.
- R5: full_mask bit i goes to 1 when the fourth byte of word i is taken. The mask fills from bit 0 upward.
- R6: out_valid rises only in the same cycle that the last word of the chain becomes full, and it never stands without every full_mask bit set.
- R7: The stream presents word 0 first and then the words in rising index order, with out_last=1 on word CHAIN_WORDS-1. While out_valid=1 and out_ready=0, out_valid, out_data and out_last hold.
- R8: The handshake of the word with out_last=1 clears out_valid and full_mask on the next edge. The next byte taken goes to byte 0 of word 0.
- R9: A byte taken while out_valid=1 is dropped and leaves the chain contents unchanged. It also sets overflow, which stays 1 until reset.
- R10: A cam_fsync rise while the chain is not full discards the partial fill: full_mask returns to 0 and the next byte is byte 0 of word 0.
- R11: reg_rdata shows word reg_sel of the chain combinationally. Reading it has no effect on the stream or on the fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cam_pclk | input | 1 | Camera pixel clock, sampled as a level |
| cam_lval | input | 1 | Line-valid strobe, high during active pixels |
| cam_fsync | input | 1 | Frame sync; a rise marks a frame start |
| cam_data | input | 8 | Camera data byte |
| swap_en | input | 1 | 1 = swap the two bytes of each pixel |
| out_valid | output | 1 | Transfer request / stream valid |
| out_ready | input | 1 | Reader accepts the presented word |
| out_data | output | 32 | Presented chain word |
| out_last | output | 1 | Presented word is the last of the chain |
| reg_sel | input | CHAIN_WORDS>1 ? $clog2(CHAIN_WORDS) : 1 | Word index for the peek port |
| reg_rdata | output | 32 | Word selected by reg_sel |
| full_mask | output | CHAIN_WORDS | Per-word full status |
| overflow | output | 1 | Sticky: a byte was dropped while the chain was full |

## Verification
The assertions assume that the camera inputs change only between system clock edges. They also assume that each pixel clock phase lasts at least one system clock, so a rising edge is seen in exactly one cycle. The reader may lower out_ready at any time, and the properties on holding the stream make no assumption about the reader. The stimulus always drives the pixel clock and the data at falling system clock edges, with each level held for at least one full cycle. Its random choices are limited to data values, out_ready and the swap setting.

// File: rtl/cam_cap_pkg.sv
package cam_cap_pkg;
  localparam int BYTE_W    = 8;
  localparam int WORD_W    = 32;
  localparam int LANES     = WORD_W / BYTE_W;

  function automatic bit depth_ok(int n);
    return (n == 1) || (n == 4) || (n == 8);
  endfunction
endpackage

// File: rtl/cam_edge_qual.sv
module cam_edge_qual (
  input  logic clk,
  input  logic rst_n,
  input  logic pclk,
  input  logic lval,
  input  logic fsync,
  output logic smp_stb,
  output logic frame_start
);
  logic pclk_q;
  logic fsync_q;
  logic armed;

  // Previous levels reset high, so a level already high at reset is not an edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pclk_q  <= 1'b1;
      fsync_q <= 1'b1;
      armed   <= 1'b0;
    end else begin
      pclk_q  <= pclk;
      fsync_q <= fsync;
      if (frame_start) armed <= 1'b1;
    end
  end

  assign frame_start = fsync & ~fsync_q;
  assign smp_stb     = armed & lval & pclk & ~pclk_q;
endmodule

// File: rtl/cam_chain_fill.sv
module cam_chain_fill
  import cam_cap_pkg::*;
#(
  parameter int WORDS = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      smp_stb,
  input  logic                      frame_start,
  input  logic [BYTE_W-1:0]         data,
  input  logic                      swap_en,
  input  logic                      drain_done,
  output logic [WORDS*WORD_W-1:0]   chain,
  output logic [WORDS-1:0]          full_mask,
  output logic                      chain_done,
  output logic                      drop_evt
);
  localparam int NB = WORDS * LANES;
  localparam int PW = $clog2(NB);

  logic [PW-1:0] pos;
  logic [PW-1:0] wp;
  logic          all_full;
  logic          wr;
  logic          restart;

  assign all_full   = &full_mask;
  assign restart    = frame_start & ~all_full;
  assign wr         = smp_stb & ~all_full & ~frame_start;
  assign drop_evt   = smp_stb & all_full;
  assign chain_done = wr && (pos == PW'(NB - 1));
  assign wp         = swap_en ? (pos ^ PW'(1)) : pos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos <= '0;
    end else if (restart) begin
      pos <= '0;
    end else if (wr) begin
      pos <= (pos == PW'(NB - 1)) ? '0 : pos + PW'(1);
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        chain[b*BYTE_W +: BYTE_W] <= '0;
      else if (wr && (wp == PW'(b)))
        chain[b*BYTE_W +: BYTE_W] <= data;
    end
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        full_mask[w] <= 1'b0;
      else if (restart || drain_done)
        full_mask[w] <= 1'b0;
      else if (wr && (pos == PW'(w*LANES + LANES - 1)))
        full_mask[w] <= 1'b1;
    end
  end
endmodule

// File: rtl/cam_chain_drain.sv
module cam_chain_drain
  import cam_cap_pkg::*;
#(
  parameter int WORDS = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    chain_done,
  input  logic [WORDS*WORD_W-1:0] chain,
  input  logic                    out_ready,
  output logic                    out_valid,
  output logic [WORD_W-1:0]       out_data,
  output logic                    out_last,
  output logic                    drain_done
);
  localparam int IW = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic [IW-1:0] rd_idx;
  logic          req;

  assign out_valid  = req;
  assign out_last   = (rd_idx == IW'(WORDS - 1));
  assign drain_done = req & out_ready & out_last;

  always_comb begin
    out_data = '0;
    for (int i = 0; i < WORDS; i++)
      if (rd_idx == IW'(i)) out_data = chain[i*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req    <= 1'b0;
      rd_idx <= '0;
    end else begin
      if (chain_done) req <= 1'b1;
      if (req && out_ready) begin
        if (out_last) begin
          req    <= 1'b0;
          rd_idx <= '0;
        end else begin
          rd_idx <= rd_idx + IW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/cam_chain_capture.sv
module cam_chain_capture
  import cam_cap_pkg::*;
#(
  parameter int CHAIN_WORDS = 8,
  localparam int SELW = (CHAIN_WORDS > 1) ? $clog2(CHAIN_WORDS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cam_pclk,
  input  logic                   cam_lval,
  input  logic                   cam_fsync,
  input  logic [BYTE_W-1:0]      cam_data,
  input  logic                   swap_en,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [WORD_W-1:0]      out_data,
  output logic                   out_last,
  input  logic [SELW-1:0]        reg_sel,
  output logic [WORD_W-1:0]      reg_rdata,
  output logic [CHAIN_WORDS-1:0] full_mask,
  output logic                   overflow
);
  if (!depth_ok(CHAIN_WORDS)) begin : g_bad_depth
    $error("CHAIN_WORDS must be 1, 4 or 8");
  end

  logic                          smp_stb;
  logic                          frame_start;
  logic                          chain_done;
  logic                          drop_evt;
  logic                          drain_done;
  logic [CHAIN_WORDS*WORD_W-1:0] chain;

  cam_edge_qual u_qual (
    .clk         (clk),
    .rst_n       (rst_n),
    .pclk        (cam_pclk),
    .lval        (cam_lval),
    .fsync       (cam_fsync),
    .smp_stb     (smp_stb),
    .frame_start (frame_start)
  );

  cam_chain_fill #(.WORDS(CHAIN_WORDS)) u_fill (
    .clk         (clk),
    .rst_n       (rst_n),
    .smp_stb     (smp_stb),
    .frame_start (frame_start),
    .data        (cam_data),
    .swap_en     (swap_en),
    .drain_done  (drain_done),
    .chain       (chain),
    .full_mask   (full_mask),
    .chain_done  (chain_done),
    .drop_evt    (drop_evt)
  );

  cam_chain_drain #(.WORDS(CHAIN_WORDS)) u_drain (
    .clk        (clk),
    .rst_n      (rst_n),
    .chain_done (chain_done),
    .chain      (chain),
    .out_ready  (out_ready),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_last   (out_last),
    .drain_done (drain_done)
  );

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < CHAIN_WORDS; i++)
      if (reg_sel == SELW'(i)) reg_rdata = chain[i*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        overflow <= 1'b0;
    else if (drop_evt) overflow <= 1'b1;
  end
endmodule

// File: rtl/cam_chain_capture_chk.sv
module cam_chain_capture_chk #(
  parameter int WORDS = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             out_valid,
  input logic             out_ready,
  input logic             out_last,
  input logic [31:0]      out_data,
  input logic [WORDS-1:0] full_mask,
  input logic             overflow
);
  AST_REQ_ALL_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (&full_mask)); // R6

  AST_FILL_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    ((full_mask & (full_mask + 1'b1)) == '0)); // R5

  AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))); // R7

  AST_DRAIN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> (!out_valid && (full_mask == '0))); // R8

  AST_NO_OVERFLOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow); // R9
endmodule

bind cam_chain_capture cam_chain_capture_chk #(.WORDS(CHAIN_WORDS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_last  (out_last),
  .out_data  (out_data),
  .full_mask (full_mask),
  .overflow  (overflow)
);

// File: tb/cam_chain_capture_bench.sv
module cam_chain_capture_bench;
  localparam int W  = 8;
  localparam int NB = W * 4;
  localparam int SW = $clog2(W);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cam_pclk = 1'b0, cam_lval = 1'b0, cam_fsync = 1'b0, swap_en = 1'b0;
  logic [7:0] cam_data = '0;
  logic out_ready = 1'b0;
  logic out_valid, out_last, overflow;
  logic [31:0] out_data, reg_rdata;
  logic [SW-1:0] reg_sel = '0;
  logic [W-1:0] full_mask;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [7:0] exp_b [NB];

  always #2.5 clk = ~clk;

  cam_chain_capture #(.CHAIN_WORDS(W)) u_cam_chain_capture (
    .clk(clk), .rst_n(rst_n), .cam_pclk(cam_pclk), .cam_lval(cam_lval),
    .cam_fsync(cam_fsync), .cam_data(cam_data), .swap_en(swap_en),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .reg_sel(reg_sel), .reg_rdata(reg_rdata),
    .full_mask(full_mask), .overflow(overflow)
  );

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(int i, bit sw);
    logic [31:0] w;
    for (int b = 0; b < 4; b++) begin
      int p = 4 * i + b;
      w[8*b +: 8] = exp_b[sw ? (p ^ 1) : p];
    end
    return w;
  endfunction

  task automatic send_byte(logic [7:0] d);
    @(negedge clk); cam_pclk = 1'b0;
    @(negedge clk); cam_pclk = 1'b1; cam_data = d;
  endtask

  task automatic frame_pulse();
    @(negedge clk); cam_fsync = 1'b1;
    @(negedge clk); cam_fsync = 1'b0;
  endtask

  task automatic fill_chain(bit sw);
    @(negedge clk); swap_en = sw; cam_lval = 1'b1;
    for (int k = 0; k < NB; k++) begin
      exp_b[k] = 8'($urandom);
      send_byte(exp_b[k]);
    end
    @(negedge clk); cam_pclk = 1'b0;
  endtask

  task automatic peek_all(bit sw, string req);
    for (int i = 0; i < W; i++) begin
      reg_sel = SW'(i); #1;
      chk(reg_rdata == exp_word(i, sw), req, reg_rdata, exp_word(i, sw));
    end
  endtask

  task automatic drain_check(bit sw);
    int k = 0;
    bit stall = 0;
    logic [31:0] held = '0;
    while (k < W) begin
      @(negedge clk); out_ready = ($urandom % 3) != 0; #1;
      if (stall) chk(out_valid && out_data == held, "R7 hold", out_data, held);
      stall = out_valid && !out_ready;
      held = out_data;
      if (out_valid && out_ready) begin
        chk(out_data == exp_word(k, sw), "R7 order/R4 data", out_data, exp_word(k, sw));
        chk(out_last == (k == W - 1), "R7 last", out_last, (k == W - 1));
        k++;
      end
    end
    @(negedge clk); out_ready = 1'b0; #1;
    chk(!out_valid && full_mask == '0, "R8 clear", {out_valid, full_mask}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0017));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(!out_valid && !overflow && full_mask == '0, "R1 reset", {out_valid, overflow, full_mask}, 0);

    // R3: edges before any frame start take nothing
    @(negedge clk); cam_lval = 1'b1;
    for (int k = 0; k < 8; k++) send_byte(8'hA0 + 8'(k));
    @(negedge clk); #1;
    chk(full_mask == '0, "R3 unarmed", full_mask, 0);

    // R2: lval rising under a parked-high pclk, and edges with lval low
    @(negedge clk); cam_lval = 1'b0;
    frame_pulse();
    for (int k = 0; k < 4; k++) send_byte(8'hEE);
    @(negedge clk); cam_pclk = 1'b1; cam_data = 8'h55;
    repeat (2) @(negedge clk);
    cam_lval = 1'b1;
    repeat (3) @(negedge clk);
    fill_chain(1'b0);
    @(negedge clk); #1;
    chk(out_valid == 1'b1, "R6 request", out_valid, 1);
    chk(&full_mask, "R5 all full", full_mask, {W{1'b1}});
    peek_all(1'b0, "R2 no spurious byte");
    peek_all(1'b0, "R11 peek no effect");
    chk(out_valid && out_data == exp_word(0, 0), "R11 stream untouched", out_data, exp_word(0, 0));
    drain_check(1'b0);

    // R5 partial fill, R10 frame start discards it
    @(negedge clk); cam_lval = 1'b1;
    for (int k = 0; k < 4; k++) send_byte(8'h11);
    @(negedge clk); cam_pclk = 1'b0; #1;
    chk(full_mask == W'(1), "R5 word0 full", full_mask, 1);
    chk(!out_valid, "R6 no early request", out_valid, 0);
    send_byte(8'h22); send_byte(8'h33);
    @(negedge clk); cam_pclk = 1'b0; #1;
    chk(full_mask == W'(1), "R5 partial word", full_mask, 1);
    frame_pulse();
    @(negedge clk); #1;
    chk(full_mask == '0, "R10 restart", full_mask, 0);
    fill_chain(1'b0);
    @(negedge clk); #1;
    peek_all(1'b0, "R10 fresh fill");
    drain_check(1'b0);

    // R4 swap
    fill_chain(1'b1);
    @(negedge clk); #1;
    peek_all(1'b1, "R4 swap");
    drain_check(1'b1);

    // R9 overflow
    fill_chain(1'b0);
    chk(!overflow, "R9 no overflow yet", overflow, 0);
    send_byte(8'hC3);
    @(negedge clk); cam_pclk = 1'b0; #1;
    chk(overflow, "R9 overflow set", overflow, 1);
    peek_all(1'b0, "R9 contents kept");
    drain_check(1'b0);
    chk(overflow, "R9 overflow held", overflow, 1);

    // R8 next byte goes to word 0 byte 0; random rounds
    for (int r = 0; r < 6; r++) begin
      bit sw = 1'($urandom);
      fill_chain(sw);
      @(negedge clk); #1;
      chk(out_valid, "R6 random request", out_valid, 1);
      drain_check(sw);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule